// File: doc/BRIEF.md
# Checkerboard RAM Self-Test Controller

This block is a built-in self-test engine for a single-port synchronous RAM. After a start pulse it writes a checkerboard pattern over the whole array, reads every word back and compares it against the pattern. It then repeats the fill and the read-back with the two patterns swapped, so that every bit of every word is seen holding a 0 and a 1. The test is destructive and leaves the final pattern in the RAM. Because the pattern depends only on the lowest address bit, the test covers stuck data bits and many coupling faults between neighbouring cells. It does not cover address lines above bit 0.

The interface to the system is a plain control and status set: a start pulse, a busy level, a done level, a fail flag, and a record of the first failing word. The RAM side is a plain single-port interface: address, write data, write enable, and read data that arrives one cycle after the address. The test has no data stream at its boundary, so there is no valid/ready handshake and no back-pressure. The RAM is assumed to accept one access in every cycle.

On the first mismatch the engine stops. It records the failing address, the expected word and the word that was read, then raises done together with fail. A start pulse in the idle or done state begins a new run and clears the previous result. A start pulse during a run has no effect.

Top module: `cbmt_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, fail_o and mem_we_o are all 0. busy_o and done_o are never 1 at the same time.
- R2: In the first fill phase the block writes addresses 0 to DEPTH-1 in ascending order, one write per cycle. The value is the byte 0x55 repeated across the word at even addresses, and the byte 0xAA repeated at odd addresses.
- R3: Within each pass, no read cycle happens before all DEPTH locations have been written. The write phase is exactly DEPTH consecutive write cycles.
- R4: The second pass writes addresses 0 to DEPTH-1 again in ascending order. This time the value is 0xAA repeated at even addresses and 0x55 repeated at odd addresses.
- R5: With a fault-free RAM, busy_o stays high for exactly 4*DEPTH+2 cycles. The run then ends with done_o=1 and fail_o=0.
- R6: A data bit stuck at 0 in one word is reported with fail_o=1. fail_addr_o gives that word's address, fail_exp_o the pattern value of the pass in which the bit should have been 1, and fail_got_o that value with the bit cleared.
- R7: A data bit stuck at 1 in one word is reported in the same way. The expected value is the pattern in which the bit should have been 0, and the read value has that bit set.
- R8: The engine stops at the first mismatch in check order. Check order is pass 1 from address 0 upward, then pass 2 from address 0 upward. While done, mem_we_o stays 0 and the fail outputs stay unchanged until the next start.
- R9: A start pulse while busy_o=1 is ignored. The run length and the write sequence are unchanged.
- R10: When DATA_W is wider than 8, each pattern is its byte repeated across the word: with 16 bits, 0x5555 and 0xAAAA.
- R11: A start pulse from the done state starts a new run and clears fail_o by the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; acted on only in the idle or done state |
| busy_o | output | 1 | High while the fill or verify phases run |
| done_o | output | 1 | High once a run has ended, until the next start |
| fail_o | output | 1 | Run ended on a mismatch (valid with done_o) |
| fail_addr_o | output | ADDR_W | Address of the first mismatching word |
| fail_exp_o | output | DATA_W | Expected value at that address |
| fail_got_o | output | DATA_W | Value read from that address |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_wdata_o | output | DATA_W | RAM write data |
| mem_we_o | output | 1 | RAM write enable |
| mem_rdata_i | input | DATA_W | RAM read data, one cycle after the address |

## Verification
The hardest case to reach from the ports is a fault that only the second pass can see. An example is a bit stuck at 0 where the first pattern already holds 0. In that case the capture logic must record the second pass's pattern as the expected value, not the first. The bench puts stuck-at masks on the read data of a behavioural RAM model, chosen so that some faults show in pass 1 and others only in pass 2. It also places two faults so that the higher address is checked first, which tests that the engine reports the first mismatch in check order. Faults at address 0 and at the last address test the ends of the read pipeline.

// File: rtl/cbmt_pkg.sv
package cbmt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL1,
    ST_VER1,
    ST_FILL2,
    ST_VER2,
    ST_DONE
  } cbmt_state_e;

  // Bit idx of the alternating pattern: with use_aa set the odd bits are 1,
  // otherwise the even bits are 1.
  function automatic logic pat_bit(input logic use_aa, input int unsigned idx);
    logic odd_bit;
    odd_bit = (idx % 2) != 0;
    return odd_bit == use_aa;
  endfunction

endpackage

// File: rtl/cbmt_pattern_gen.sv
module cbmt_pattern_gen #(
  parameter int DATA_W = 8
) (
  input  logic              pass2_i,
  input  logic              odd_i,
  output logic [DATA_W-1:0] pat_o
);
  logic use_aa;
  assign use_aa = pass2_i ^ odd_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign pat_o[i] = cbmt_pkg::pat_bit(use_aa, i);
  end
endmodule

// File: rtl/cbmt_addr_seq.sv
module cbmt_addr_seq #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o,
  output logic             end_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end

  assign last_o = (cnt_o == CNT_W'(DEPTH - 1));
  assign end_o  = (cnt_o == CNT_W'(DEPTH));
endmodule

// File: rtl/cbmt_read_check.sv
module cbmt_read_check #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              issue_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              mismatch_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_got_o
);
  logic              vld_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] exp_q;

  // Read data belongs to the address issued one cycle earlier.
  assign mismatch_o = vld_q && (rdata_i != exp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      exp_q  <= '0;
    end else begin
      vld_q <= issue_i && !mismatch_o && !clr_i;
      if (issue_i) begin
        addr_q <= addr_i;
        exp_q  <= exp_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_o      <= 1'b0;
      fail_addr_o <= '0;
      fail_exp_o  <= '0;
      fail_got_o  <= '0;
    end else if (clr_i) begin
      fail_o      <= 1'b0;
      fail_addr_o <= '0;
      fail_exp_o  <= '0;
      fail_got_o  <= '0;
    end else if (mismatch_o && !fail_o) begin
      fail_o      <= 1'b1;
      fail_addr_o <= addr_q;
      fail_exp_o  <= exp_q;
      fail_got_o  <= rdata_i;
    end
  end
endmodule

// File: rtl/cbmt_ctrl.sv
module cbmt_ctrl #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_got_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  import cbmt_pkg::*;

  localparam int CNT_W = ADDR_W + 1;

  cbmt_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt;
  logic             cnt_last, cnt_end;
  logic             start_acc, in_fill, in_ver, pass2, issue_rd;
  logic             seq_clr, seq_inc, mismatch;
  logic [DATA_W-1:0] pat;

  assign start_acc = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));
  assign in_fill   = (state_q == ST_FILL1) || (state_q == ST_FILL2);
  assign in_ver    = (state_q == ST_VER1)  || (state_q == ST_VER2);
  assign pass2     = (state_q == ST_FILL2) || (state_q == ST_VER2);
  assign issue_rd  = in_ver && !cnt_end;

  assign seq_clr = start_acc || (in_fill && cnt_last) || (in_ver && cnt_end);
  assign seq_inc = in_fill || issue_rd;

  cbmt_addr_seq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (seq_clr),
    .inc_i  (seq_inc),
    .cnt_o  (cnt),
    .last_o (cnt_last),
    .end_o  (cnt_end)
  );

  cbmt_pattern_gen #(.DATA_W(DATA_W)) u_pat (
    .pass2_i (pass2),
    .odd_i   (cnt[0]),
    .pat_o   (pat)
  );

  cbmt_read_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (start_acc),
    .issue_i     (issue_rd),
    .addr_i      (cnt[ADDR_W-1:0]),
    .exp_i       (pat),
    .rdata_i     (mem_rdata_i),
    .mismatch_o  (mismatch),
    .fail_o      (fail_o),
    .fail_addr_o (fail_addr_o),
    .fail_exp_o  (fail_exp_o),
    .fail_got_o  (fail_got_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start_acc) state_d = ST_FILL1;
      ST_FILL1:         if (cnt_last)  state_d = ST_VER1;
      ST_VER1: begin
        if (mismatch)     state_d = ST_DONE;
        else if (cnt_end) state_d = ST_FILL2;
      end
      ST_FILL2:         if (cnt_last)  state_d = ST_VER2;
      ST_VER2: begin
        if (mismatch || cnt_end) state_d = ST_DONE;
      end
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign mem_addr_o  = cnt[ADDR_W-1:0];
  assign mem_we_o    = in_fill;
  assign mem_wdata_o = pat;
  assign busy_o      = in_fill || in_ver;
  assign done_o      = (state_q == ST_DONE);
endmodule

// File: rtl/cbmt_ctrl_chk.sv
module cbmt_ctrl_chk #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_i,
  input logic                  busy_o,
  input logic                  done_o,
  input logic                  fail_o,
  input logic [ADDR_W-1:0]     fail_addr_o,
  input logic [ADDR_W-1:0]     mem_addr_o,
  input logic [DATA_W-1:0]     mem_wdata_o,
  input logic                  mem_we_o,
  input cbmt_pkg::cbmt_state_e state_q
);
  import cbmt_pkg::*;

  function automatic logic [DATA_W-1:0] alt_word(input bit odd_ones);
    logic [DATA_W-1:0] w;
    for (int i = 0; i < DATA_W; i++) w[i] = ((i % 2) == 1) == odd_ones;
    return w;
  endfunction

  localparam logic [DATA_W-1:0] W55 = alt_word(1'b0);
  localparam logic [DATA_W-1:0] WAA = alt_word(1'b1);

  logic [31:0] wr_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wr_run_q <= '0;
    else if (mem_we_o) wr_run_q <= wr_run_q + 1;
    else               wr_run_q <= '0;
  end

  a_r1_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));
  a_r2_fill1_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL1) |-> (mem_wdata_o == (mem_addr_o[0] ? WAA : W55)));
  a_r4_fill2_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL2) |-> (mem_wdata_o == (mem_addr_o[0] ? W55 : WAA)));
  a_r3_full_fill: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_we_o) && busy_o) |-> (wr_run_q == DEPTH));
  a_r6_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> done_o);
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_we_o);
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(fail_o) && $stable(fail_addr_o)));
  a_r9_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));
endmodule

bind cbmt_ctrl cbmt_ctrl_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .fail_addr_o (fail_addr_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_we_o    (mem_we_o),
  .state_q     (state_q)
);

// File: tb/cbmt_ctrl_tb_top.sv
module cbmt_ctrl_tb_top;
  localparam int D  = 64;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int AWW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic start_w = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;

  // main DUT, 8-bit
  logic          busy, done, fail, we;
  logic [AW-1:0] faddr, addr;
  logic [7:0]    fexp, fgot, wdata, rdata;

  cbmt_ctrl #(.DEPTH(D), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .busy_o(busy), .done_o(done), .fail_o(fail),
    .fail_addr_o(faddr), .fail_exp_o(fexp), .fail_got_o(fgot),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_we_o(we), .mem_rdata_i(rdata));

  logic [7:0] mem [D];
  logic [7:0] sa0 [D];
  logic [7:0] sa1 [D];
  always @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= (mem[addr] & ~sa0[addr]) | sa1[addr];
  end

  // wide DUT, 16-bit, depth 8
  logic           busy_w, done_w, fail_w, we_w;
  logic [AWW-1:0] faddr_w, addr_w;
  logic [DW-1:0]  fexp_w, fgot_w, wdata_w, rdata_w;

  cbmt_ctrl #(.DEPTH(8), .DATA_W(DW)) dut_w_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_w),
    .busy_o(busy_w), .done_o(done_w), .fail_o(fail_w),
    .fail_addr_o(faddr_w), .fail_exp_o(fexp_w), .fail_got_o(fgot_w),
    .mem_addr_o(addr_w), .mem_wdata_o(wdata_w), .mem_we_o(we_w), .mem_rdata_i(rdata_w));

  logic [DW-1:0] mem_w [8];
  always @(posedge clk) begin
    if (we_w) mem_w[addr_w] <= wdata_w;
    rdata_w <= mem_w[addr_w];
  end

  function automatic logic [7:0] exp8(input int pass, input int a);
    return (((a % 2) ^ pass) != 0) ? 8'hAA : 8'h55;
  endfunction
  function automatic logic [DW-1:0] exp16(input int pass, input int a);
    return (((a % 2) ^ pass) != 0) ? 16'hAAAA : 16'h5555;
  endfunction

  // write-sequence monitors
  int wr_n = 0, wr_bad = 0, rd_early = 0;
  int wr_n_w = 0, wr_bad_w = 0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (we) begin
        if (wr_n >= 2*D || int'(addr) != wr_n % D || wdata != exp8(wr_n / D, wr_n % D))
          wr_bad++;
        wr_n++;
      end else if (busy && wr_n != D && wr_n != 2*D) begin
        rd_early++;
      end
      if (we_w) begin
        if (wr_n_w >= 16 || int'(addr_w) != wr_n_w % 8 ||
            wdata_w != exp16(wr_n_w / 8, wr_n_w % 8))
          wr_bad_w++;
        wr_n_w++;
      end
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic clear_faults();
    for (int i = 0; i < D; i++) begin sa0[i] = 8'h00; sa1[i] = 8'h00; end
  endtask

  // Runs one test; busy_cycles counts cycles with busy high.
  task automatic run_dut(input bit mid_start, output int busy_cycles, output bit fail_at_begin);
    int guard;
    wr_n = 0; wr_bad = 0; rd_early = 0;
    busy_cycles = 0; guard = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fail_at_begin = fail;
    while (!done && guard < 2000) begin
      if (busy) busy_cycles++;
      start = (mid_start && busy_cycles == 10);
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "busy after reset", busy, 0);
    check("R1", "done after reset", done, 0);
    check("R1", "fail after reset", fail, 0);
    check("R1", "we after reset",   we, 0);
  endtask

  task automatic t_clean(input bit mid_start, input string req);
    int bc; bit fb;
    clear_faults();
    run_dut(mid_start, bc, fb);
    check(req,  "busy cycles", bc, 4*D+2);
    check("R5", "done", done, 1);
    check("R5", "fail clean", fail, 0);
    check("R2", "write sequence errors (both passes, R4)", wr_bad, 0);
    check("R4", "total writes", wr_n, 2*D);
    check("R3", "reads before full fill", rd_early, 0);
  endtask

  // Single stuck bit at address a, bit b; stuck_one selects stuck-at-1.
  task automatic t_fault(input int a, input int b, input bit stuck_one, input string req);
    int bc; bit fb;
    logic [7:0] m, p1, p2, e, g;
    logic [AW-1:0] fa_hold;
    clear_faults();
    m = 8'(1 << b);
    if (stuck_one) sa1[a] = m; else sa0[a] = m;
    p1 = exp8(0, a); p2 = exp8(1, a);
    e = (((stuck_one ? (p1 | m) : (p1 & ~m))) != p1) ? p1 : p2;
    g = stuck_one ? (e | m) : (e & ~m);
    run_dut(1'b0, bc, fb);
    check(req, "done", done, 1);
    check(req, "fail", fail, 1);
    check(req, "fail addr", faddr, a);
    check(req, "fail exp", fexp, e);
    check(req, "fail got", fgot, g);
    fa_hold = faddr;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R8", "no write when done", we, 0);
    end
    check("R8", "fail addr holds", faddr, fa_hold);
  endtask

  task automatic t_two_faults();
    int bc; bit fb;
    clear_faults();
    sa0[9]  = 8'h01;   // odd: visible only in pass 2
    sa0[12] = 8'h01;   // even: visible in pass 1
    run_dut(1'b0, bc, fb);
    check("R8", "first in check order", faddr, 12);
    check("R8", "first exp", fexp, 8'h55);
  endtask

  task automatic t_restart();
    int bc; bit fb;
    clear_faults();
    sa1[3] = 8'h80;
    run_dut(1'b0, bc, fb);
    check("R11", "setup fail", fail, 1);
    clear_faults();
    run_dut(1'b0, bc, fb);
    check("R11", "fail cleared after start", fb, 0);
    check("R11", "rerun clean", fail, 0);
    check("R11", "rerun cycles", bc, 4*D+2);
  endtask

  task automatic t_wide();
    int guard;
    wr_n_w = 0; wr_bad_w = 0; guard = 0;
    start_w = 1'b1;
    @(negedge clk);
    start_w = 1'b0;
    while (!done_w && guard < 500) begin @(negedge clk); guard++; end
    check("R10", "wide write pattern errors", wr_bad_w, 0);
    check("R10", "wide writes", wr_n_w, 16);
    check("R10", "wide done", done_w, 1);
    check("R10", "wide fail", fail_w, 0);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_faults();
    for (int i = 0; i < D; i++) mem[i] = 8'h00;
    for (int i = 0; i < 8; i++) mem_w[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean(1'b0, "R5");
    t_clean(1'b1, "R9");
    t_fault(0,  0, 1'b0, "R6");
    t_fault(20, 1, 1'b0, "R6");
    t_fault(D-1, 0, 1'b1, "R7");
    t_fault(7,  7, 1'b1, "R7");
    t_two_faults();
    t_restart();
    t_wide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule